// File: doc/BRIEF.md
# Boundary-Checked Serial Word Receiver

This block sits behind a clock-recovery and line-decoding front end and turns a recovered serial bit stream, one bit per clock, back into parallel words. Each frame on the line is 25 bits long: a leading zero guard bit, 22 payload bits sent least significant first, and two trailing boundary bits. Both boundary bits must carry the inverse of payload bit 21, which guarantees at least one level change in every frame. The receiver uses this pattern, with no comma or sync word, to find the frame boundary. It slides a frame-wide window one bit at a time until it sees a candidate frame. It then requires a run of consecutive good frames at that alignment before it declares lock.

Once locked, every frame's guard and boundary bits are checked. Each good frame is delivered on `word_out`, followed one clock later by a single-cycle rising pulse on `word_clk`. A bad frame starts a power-down handshake toward the transmitter. The receiver drops lock and raises `pullup_req`, which asks the line to be pulled high. It holds that request until the transmitter stops driving the line (`line_driven` low). It then waits for the line to be driven again and re-acquires alignment from scratch. A separate commanded power-down input (`link_en` low) parks the receiver and disables the handshake entirely.

Top module: `frame_word_rx`

## Requirements
- R1: A delivered word equals the 22 payload bits of a frame. The payload bit received first after the zero guard bit lands on `word_out[0]`, and the last one lands on `word_out[21]`.
- R2: Lock is declared on the 4th consecutive frame, at one alignment, that has a zero guard bit and both boundary bits equal to the inverse of payload bit 21. That 4th frame is the first word delivered, and no earlier frame is delivered.
- R3: When the line starts at an arbitrary bit offset, acquisition slides one bit per clock until a window passes the frame check. It then locks on the true frame alignment.
- R4: A failed frame check before lock resumes the bit-by-bit search and restarts the count of consecutive good frames from zero.
- R5: While locked, a frame with either boundary bit (line position 23 or 24 of the frame) not equal to the inverse of payload bit 21 drops `locked` and raises `pullup_req` within one clock of the frame check. `pullup_req` is never high while `locked` is high.
- R6: `pullup_req` stays high while `line_driven` stays high. It is released on the clock after `line_driven` is seen low, and the receiver does not resume the search until `line_driven` is high again.
- R7: After a handshake, once the line is driven again from a frame start, the receiver re-locks and delivers words again under R2.
- R8: `word_clk` is high for exactly one clock per delivered word. It rises one clock after `word_out` takes the new word, so `word_out` is stable at each rising edge of `word_clk`.
- R9: While not locked, including during search, after a fault and while the line is not driven, `word_out` is zero and `word_clk` stays low.
- R10: With `link_en` low, the receiver is idle and not locked, and `pullup_req` is low on the next clock. Corrupt frames received then raise no pull-up request.
- R11: After reset, `word_out`, `word_clk`, `locked` and `pullup_req` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | High for normal operation, low for commanded power-down |
| line_driven | input | 1 | High while the transmitter is actively driving the line |
| ser_bit | input | 1 | Recovered serial data bit |
| word_out | output | 22 | Delivered payload word, zero when not locked |
| word_clk | output | 1 | Output word clock, a one-cycle pulse after each delivered word |
| locked | output | 1 | Frame alignment is established |
| pullup_req | output | 1 | Request to pull the line high after a framing error |

## Verification
The bench starts the line at a frame start and at a three-bit offset, so it can catch a receiver that locks at a wrong phase or stalls in search. Such a receiver would deliver shifted words or none at all. It corrupts one boundary bit before lock, on the third frame. A receiver that kept its good-frame count through the failure would lock early and emit unexpected words. It also corrupts each of the two boundary bits while locked. A receiver that checked only one twin would keep delivering, and one that released the pull-up request early or ignored `line_driven` would be caught by the handshake checks. Finally, it drops `link_en` and feeds a corrupt frame, which exposes a receiver whose handshake still fires during commanded power-down.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_HUNT,
    ST_VERIFY,
    ST_LOCKED,
    ST_FAULT
  } rx_state_t;
endpackage

// File: rtl/frx_window.sv
// Frame-wide shift window; the oldest bit sits at index 0.
module frx_window #(
  parameter int FRAME_W = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] win
);
  always_ff @(posedge clk) begin
    if (rst) begin
      win <= '0;
    end else if (shift_en) begin
      win <= {bit_in, win[FRAME_W-1:1]};
    end
  end
endmodule

// File: rtl/frx_frame_check.sv
// Combinational frame test: zero guard, every boundary bit inverse of last payload bit.
module frx_frame_check #(
  parameter int DATA_W = 22,
  parameter int BND_W  = 2,
  localparam int FRAME_W = 1 + DATA_W + BND_W
) (
  input  logic [FRAME_W-1:0] win,
  output logic               frame_ok,
  output logic [DATA_W-1:0]  payload
);
  logic [BND_W-1:0] bnd_ok;

  for (genvar i = 0; i < BND_W; i++) begin : g_bnd
    assign bnd_ok[i] = (win[DATA_W+1+i] == ~win[DATA_W]);
  end

  assign payload  = win[DATA_W:1];
  assign frame_ok = ~win[0] & (&bnd_ok);
endmodule

// File: rtl/frx_outreg.sv
// Output word register and word clock; the pulse trails the data by one cycle.
module frx_outreg #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              keep,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] word_out,
  output logic              word_clk
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst || !keep) begin
      word_out <= '0;
      pend     <= 1'b0;
      word_clk <= 1'b0;
    end else begin
      if (load) word_out <= data_in;
      pend     <= load;
      word_clk <= pend;
    end
  end
endmodule

// File: rtl/frame_word_rx.sv
module frame_word_rx #(
  parameter int DATA_W      = 22,
  parameter int BND_W       = 2,
  parameter int LOCK_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_en,
  input  logic              line_driven,
  input  logic              ser_bit,
  output logic [DATA_W-1:0] word_out,
  output logic              word_clk,
  output logic              locked,
  output logic              pullup_req
);
  import fwr_pkg::*;

  localparam int FRAME_W = 1 + DATA_W + BND_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int GOOD_W  = $clog2(LOCK_FRAMES + 1);

  rx_state_t          st, st_n;
  logic [CNT_W-1:0]   seen, seen_n;
  logic [CNT_W-1:0]   pos, pos_n;
  logic [GOOD_W-1:0]  good, good_n;
  logic               pull_n;
  logic               shift_en;
  logic               deliver;
  logic [FRAME_W-1:0] win;
  logic               frame_ok;
  logic [DATA_W-1:0]  payload;

  frx_window #(.FRAME_W(FRAME_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (ser_bit),
    .win      (win)
  );

  frx_frame_check #(.DATA_W(DATA_W), .BND_W(BND_W)) u_chk (
    .win      (win),
    .frame_ok (frame_ok),
    .payload  (payload)
  );

  frx_outreg #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .keep     (st_n == ST_LOCKED),
    .load     (deliver),
    .data_in  (payload),
    .word_out (word_out),
    .word_clk (word_clk)
  );

  always_comb begin
    st_n     = st;
    seen_n   = seen;
    pos_n    = pos;
    good_n   = good;
    pull_n   = pullup_req;
    shift_en = 1'b0;
    deliver  = 1'b0;
    if (!link_en) begin
      st_n   = ST_OFF;
      pull_n = 1'b0;
    end else begin
      case (st)
        ST_OFF: begin
          pull_n = 1'b0;
          if (line_driven) begin
            st_n   = ST_HUNT;
            seen_n = '0;
          end
        end
        ST_FAULT: begin
          pull_n = 1'b1;
          if (!line_driven) begin
            st_n   = ST_OFF;
            pull_n = 1'b0;
          end
        end
        default: begin
          if (!line_driven) begin
            st_n = ST_OFF;
          end else begin
            shift_en = 1'b1;
            if (st == ST_HUNT) begin
              if (seen != CNT_W'(FRAME_W)) seen_n = seen + 1'b1;
              if (seen == CNT_W'(FRAME_W) && frame_ok) begin
                pos_n  = CNT_W'(1);
                good_n = GOOD_W'(1);
                if (LOCK_FRAMES == 1) begin
                  st_n    = ST_LOCKED;
                  deliver = 1'b1;
                end else begin
                  st_n = ST_VERIFY;
                end
              end
            end else begin
              pos_n = pos + 1'b1;
              if (pos == CNT_W'(FRAME_W)) begin
                pos_n = CNT_W'(1);
                if (frame_ok) begin
                  if (st == ST_LOCKED) begin
                    deliver = 1'b1;
                  end else begin
                    good_n = good + 1'b1;
                    if (good + 1'b1 == GOOD_W'(LOCK_FRAMES)) begin
                      st_n    = ST_LOCKED;
                      deliver = 1'b1;
                    end
                  end
                end else if (st == ST_LOCKED) begin
                  st_n   = ST_FAULT;
                  pull_n = 1'b1;
                end else begin
                  st_n = ST_HUNT;
                end
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OFF;
      seen       <= '0;
      pos        <= '0;
      good       <= '0;
      pullup_req <= 1'b0;
    end else begin
      st         <= st_n;
      seen       <= seen_n;
      pos        <= pos_n;
      good       <= good_n;
      pullup_req <= pull_n;
    end
  end

  assign locked = (st == ST_LOCKED);
endmodule

// File: rtl/frame_word_rx_chk.sv
module frame_word_rx_chk #(
  parameter int DATA_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              link_en,
  input logic              line_driven,
  input logic [DATA_W-1:0] word_out,
  input logic              word_clk,
  input logic              locked,
  input logic              pullup_req
);
  p_pull_unlocked_r5: assert property (@(posedge clk) disable iff (rst)
    pullup_req |-> !locked);

  p_pull_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pullup_req && line_driven && link_en) |=> pullup_req);

  p_pull_release_r6: assert property (@(posedge clk) disable iff (rst)
    (pullup_req && !line_driven) |=> !pullup_req);

  p_strobe_stable_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(word_clk) |-> $stable(word_out));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    word_clk |=> !word_clk);

  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (word_out == '0 && !word_clk));

  p_parked_r10: assert property (@(posedge clk) disable iff (rst)
    !link_en |=> (!pullup_req && !locked));
endmodule

bind frame_word_rx frame_word_rx_chk #(.DATA_W(DATA_W)) u_props (
  .clk         (clk),
  .rst         (rst),
  .link_en     (link_en),
  .line_driven (line_driven),
  .word_out    (word_out),
  .word_clk    (word_clk),
  .locked      (locked),
  .pullup_req  (pullup_req)
);

// File: tb/frame_word_rx_test.sv
`timescale 1ns/1ps
module frame_word_rx_test;
  localparam int DW = 22;
  localparam int FW = DW + 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          link_en;
  logic          line_driven;
  logic          ser_bit;
  logic [DW-1:0] word_out;
  logic          word_clk;
  logic          locked;
  logic          pullup_req;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DW-1:0] expq [0:511];
  int wr = 0;
  int rd = 0;

  always #2 clk = ~clk;

  frame_word_rx uut (
    .clk(clk), .rst(rst), .link_en(link_en), .line_driven(line_driven),
    .ser_bit(ser_bit), .word_out(word_out), .word_clk(word_clk),
    .locked(locked), .pullup_req(pullup_req)
  );

  task automatic check(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk_frame(logic [DW-1:0] d);
    logic [FW-1:0] f;
    f[0]       = 1'b0;
    f[DW:1]    = d;
    f[DW+1]    = ~d[DW-1];
    f[DW+2]    = ~d[DW-1];
    return f;
  endfunction

  // Word monitor: every strobe must match the next expected word (R1, R8, R9)
  always @(negedge clk) begin
    if (!rst && word_clk) begin
      n_checks++;
      if (rd >= wr) begin
        n_fails++;
        $display("FAIL R9 unexpected strobe act=%0h exp=none", word_out);
      end else begin
        if (word_out !== expq[rd]) begin
          n_fails++;
          $display("FAIL R1 word act=%0h exp=%0h", word_out, expq[rd]);
        end
        rd++;
      end
    end
  end

  task automatic send_bit(logic b);
    @(negedge clk);
    ser_bit = b;
  endtask

  // nfr frames after prefix one-bits; frame bad_idx gets bit bad_bit flipped;
  // frames from first_deliv on (except the bad one) are expected on the output.
  task automatic session(int nfr, int prefix, bit ones, int bad_idx, int bad_bit,
                         int first_deliv);
    @(negedge clk);
    link_en     = 1'b1;
    line_driven = 1'b1;
    for (int p = 0; p < prefix; p++) send_bit(1'b1);
    for (int k = 0; k < nfr; k++) begin
      logic [DW-1:0] d;
      logic [FW-1:0] f;
      d = ones ? '1 : DW'($urandom);
      f = mk_frame(d);
      if (k == bad_idx) f[bad_bit] = ~f[bad_bit];
      if (k >= first_deliv && k != bad_idx) begin
        expq[wr] = d;
        wr++;
      end
      for (int i = 0; i < FW; i++) send_bit(f[i]);
    end
    for (int t = 0; t < 3; t++) send_bit(1'b0);
  endtask

  task automatic end_line(string tag);
    @(negedge clk);
    line_driven = 1'b0;
    @(negedge clk);
    check({tag, " all expected words delivered"}, rd, wr);
    check("R9 unlocked after line drop", locked, 0);
    check("R9 word zero after line drop", word_out, 0);
    check("R6 no pull-up after line drop", pullup_req, 0);
  endtask

  initial begin
    int seed_sink;
    seed_sink   = $urandom(32'h5EED_0042);
    rst         = 1'b1;
    link_en     = 1'b0;
    line_driven = 1'b0;
    ser_bit     = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 reset word_out", word_out, 0);
    check("R11 reset word_clk", word_clk, 0);
    check("R11 reset locked", locked, 0);
    check("R11 reset pullup_req", pullup_req, 0);
    rst = 1'b0;

    // R1, R2: aligned random sessions of varying length
    for (int s = 0; s < 3; s++) begin
      session(5 + int'($urandom % 5), 0, 1'b0, -1, 0, 3);
      check("R2 locked at session end", locked, 1);
      end_line("R2");
    end

    // R3: start three bits off a frame boundary
    session(7, 3, 1'b1, -1, 0, 3);
    end_line("R3");

    // R4: boundary error on the third frame, before lock; lock moves to frame 6
    session(10, 0, 1'b1, 2, DW + 2, 6);
    end_line("R4");

    // R5, R6, R7: each boundary twin corrupted while locked
    for (int b = DW + 1; b <= DW + 2; b++) begin
      session(7, 0, 1'b0, 6, b, 3);
      check("R5 pull-up after boundary error", pullup_req, 1);
      check("R5 lock dropped", locked, 0);
      check("R9 word zero after fault", word_out, 0);
      for (int t = 0; t < 8; t++) send_bit(1'($urandom));
      check("R6 pull-up held while line driven", pullup_req, 1);
      @(negedge clk);
      line_driven = 1'b0;
      @(negedge clk);
      check("R6 pull-up released", pullup_req, 0);
      repeat (5) @(negedge clk);
      check("R6 idle while line undriven", locked, 0);
      check("R2 fault session words", rd, wr);
      session(8, 0, 1'b0, -1, 0, 3);
      check("R7 re-locked", locked, 1);
      end_line("R7");
    end

    // R10: commanded power-down masks the handshake
    session(6, 0, 1'b0, -1, 0, 3);
    @(negedge clk);
    link_en = 1'b0;
    begin
      logic [FW-1:0] bad;
      bad = mk_frame(DW'($urandom));
      bad[0] = 1'b1;
      bad[DW+1] = ~bad[DW+1];
      for (int i = 0; i < FW; i++) send_bit(bad[i]);
    end
    @(negedge clk);
    check("R10 no pull-up in power-down", pullup_req, 0);
    check("R10 unlocked in power-down", locked, 0);
    check("R10 word zero in power-down", word_out, 0);
    session(6, 0, 1'b0, -1, 0, 3);
    check("R10 re-locked after power-up", locked, 1);
    end_line("R10");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule